// File: doc/BRIEF.md
# Calibration Drift Bit Receiver

This block recovers a slow covert data stream from the delay-tap settings that a memory read-path calibration engine keeps re-computing for its strobe-aligned byte lanes. An external transmitter deliberately loads a lane's strobe trace. The extra delay pulls that lane's calibrated tap value downwards, because the calibration engine compensates for the slower edge. Each lane is judged on its own. At every recalibration round, the lane's fresh tap value is compared with a baseline stored for that lane, and the difference is turned into one bit.

The first recalibration after reset, or after a re-baseline command, only records the baseline and produces no output. Each later round yields one bit per lane. A drop of at least the threshold, and no more than the maximum range, is the loaded symbol (1). Any other in-range result is the unloaded symbol (0). A shift in either direction that is larger than the maximum range sets the lane's error flag instead of a data bit. The results appear one cycle after the recalibration strobe, together with a single-cycle valid pulse, and they hold until the next round. The calibration engine and the delay lines are outside the block. They are represented by the packed tap input and the round strobe.

Top module: `tap_drift_rx`

## Requirements
- R1: While reset is held and after it is released, `round_valid`, `lane_bits` and `lane_err` are all zero until a decoding round completes.
- R2: The first `recal_done` after reset only stores every lane's tap value as its baseline. No `round_valid` pulse follows it and the outputs stay zero.
- R3: For each later `recal_done`, `round_valid` is high for exactly the next cycle only, and the new `lane_bits`/`lane_err` appear in that same cycle.
- R4: A lane whose tap fell below its baseline by THRESH (default 3) up to MAX_SHIFT (default 12) taps, inclusive, reports bit 1 and error 0.
- R5: A lane whose tap differs from its baseline by less than THRESH taps, in either direction, reports bit 0 and error 0.
- R6: A lane whose tap rose above its baseline by THRESH up to MAX_SHIFT taps reports bit 0 and error 0.
- R7: A lane whose tap moved more than MAX_SHIFT taps from its baseline, in either direction, reports error 1 and bit 0.
- R8: Lane i takes its 6-bit tap from `tap_in[6*i+5 : 6*i]` and reports on `lane_bits[i]`/`lane_err[i]`. Each lane is decided only from its own tap and its own baseline.
- R9: After a `rebase` pulse, the next `recal_done` re-captures all baselines without a valid pulse. A `rebase` that coincides with `recal_done` applies to that same round.
- R10: Decoding rounds never change the baselines, and `lane_bits`/`lane_err` hold their values between rounds.
- R11: `tap_in` has no effect in cycles without `recal_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| recal_done | input | 1 | One-cycle strobe: a recalibration round finished and `tap_in` is current |
| rebase | input | 1 | Request to re-capture all baselines at the next round |
| tap_in | input | LANES*TAP_W (48) | Packed per-lane calibrated tap values, lane 0 in the low bits |
| round_valid | output | 1 | One-cycle pulse marking a new decoded round |
| lane_bits | output | LANES (8) | Decoded symbol per lane, 1 = loaded |
| lane_err | output | LANES (8) | Per-lane out-of-range flag for the latest round |

## Verification
A corrupted baseline register does not show up straight away. It appears at the next decoding round as a wrong bit or a spurious error on that lane only. The bench therefore follows every baseline change with rounds whose deltas sit exactly on the THRESH and MAX_SHIFT edges. A stuck or mis-set baseline-present flag shows up one cycle after a strobe, as a valid pulse where none is allowed or as a missing pulse. Lanes are given different deltas in the same round, so a crossed lane slice is caught in that round.

// File: rtl/tdr_pkg.sv
// Package: shared types and helpers for the calibration drift receiver.
// Assumes tap values are unsigned binary delay-line settings.
package tdr_pkg;

    // Classification of one lane in one round
    typedef enum logic [1:0] {
        SYM_UNLOADED = 2'd0,
        SYM_LOADED   = 2'd1,
        SYM_RANGE    = 2'd2
    } sym_e;

endpackage

// File: rtl/tdr_round_ctrl.sv
// Round controller: tracks whether baselines are present and splits each
// recalibration strobe into either a baseline capture or a decode round.
// Assumes recal_done and rebase are single-cycle, synchronous strobes.
module tdr_round_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic recal_done,
    input  logic rebase,
    output logic capture,
    output logic decide,
    output logic have_base,
    output logic valid_q
);

    logic need_base;

    // Baselines are (re)taken when absent or when a rebase arrives this cycle
    always_comb begin
        need_base = !have_base || rebase;
        capture   = recal_done && need_base;
        decide    = recal_done && !need_base;
    end

    // Baseline-present flag: set on capture, cleared by a lone rebase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_base <= 1'b0;
        end else if (capture) begin
            have_base <= 1'b1;
        end else if (rebase) begin
            have_base <= 1'b0;
        end
    end

    // Round valid pulse, one cycle after a decode strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= decide;
        end
    end

endmodule

// File: rtl/tdr_lane_base.sv
// Lane baseline register: holds the reference tap of one lane.
// Assumes capture is asserted only in cycles where the tap input is current.
module tdr_lane_base #(
    parameter int TAP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [TAP_W-1:0] tap,
    output logic [TAP_W-1:0] base_q
);

    // Store the tap value when the controller requests a capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (capture) begin
            base_q <= tap;
        end
    end

endmodule

// File: rtl/tdr_lane_decode.sv
// Lane decoder: classifies the shift of a lane's tap against its baseline.
// A drop of THRESH..MAX_SHIFT taps is the loaded symbol; a shift beyond
// MAX_SHIFT either way is a range error; anything else is unloaded.
// Assumes 1 <= THRESH <= MAX_SHIFT < 2**TAP_W.
module tdr_lane_decode
    import tdr_pkg::*;
#(
    parameter int TAP_W     = 6,
    parameter int THRESH    = 3,
    parameter int MAX_SHIFT = 12
) (
    input  logic [TAP_W-1:0] base,
    input  logic [TAP_W-1:0] tap,
    output sym_e             sym
);

    localparam int DW = TAP_W + 1;
    localparam logic signed [DW-1:0] THR_S = DW'(THRESH);
    localparam logic signed [DW-1:0] MAX_S = DW'(MAX_SHIFT);

    logic signed [DW-1:0] drop;
    logic signed [DW-1:0] mag;

    // Signed drop of the tap (positive = tap fell) and its magnitude
    always_comb begin
        drop = $signed({1'b0, base}) - $signed({1'b0, tap});
        mag  = (drop < 0) ? -drop : drop;
    end

    // Symbol decision: range check first, then the loaded window
    always_comb begin
        if (mag > MAX_S) begin
            sym = SYM_RANGE;
        end else if (drop >= THR_S) begin
            sym = SYM_LOADED;
        end else begin
            sym = SYM_UNLOADED;
        end
    end

endmodule

// File: rtl/tap_drift_rx.sv
// Top: per-lane calibration drift receiver. One baseline register and
// one decoder per lane, a shared round controller, and registered
// per-lane bit and error outputs that hold between rounds.
// Assumes tap_in is stable in the cycle recal_done is high.
module tap_drift_rx
    import tdr_pkg::*;
#(
    parameter int LANES     = 8,
    parameter int TAP_W     = 6,
    parameter int THRESH    = 3,
    parameter int MAX_SHIFT = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   recal_done,
    input  logic                   rebase,
    input  logic [LANES*TAP_W-1:0] tap_in,
    output logic                   round_valid,
    output logic [LANES-1:0]       lane_bits,
    output logic [LANES-1:0]       lane_err
);

    logic capture;
    logic decide;
    logic have_base;

    logic [LANES-1:0] bit_d;
    logic [LANES-1:0] err_d;

    tdr_round_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .recal_done (recal_done),
        .rebase     (rebase),
        .capture    (capture),
        .decide     (decide),
        .have_base  (have_base),
        .valid_q    (round_valid)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [TAP_W-1:0] tap;
        logic [TAP_W-1:0] base;
        sym_e             sym;

        assign tap = tap_in[g*TAP_W +: TAP_W];

        tdr_lane_base #(.TAP_W(TAP_W)) u_base (
            .clk     (clk),
            .rst_n   (rst_n),
            .capture (capture),
            .tap     (tap),
            .base_q  (base)
        );

        tdr_lane_decode #(
            .TAP_W     (TAP_W),
            .THRESH    (THRESH),
            .MAX_SHIFT (MAX_SHIFT)
        ) u_dec (
            .base (base),
            .tap  (tap),
            .sym  (sym)
        );

        // Map the lane symbol onto its bit and error lines
        always_comb begin
            bit_d[g] = (sym == SYM_LOADED);
            err_d[g] = (sym == SYM_RANGE);
        end
    end

    // Output registers: load on a decode round, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_bits <= '0;
            lane_err  <= '0;
        end else if (decide) begin
            lane_bits <= bit_d;
            lane_err  <= err_d;
        end
    end

endmodule

// File: rtl/tap_drift_rx_chk.sv
// Checker: temporal properties of the drift receiver, bound to the top.
module tap_drift_rx_chk #(
    parameter int LANES = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             recal_done,
    input logic             rebase,
    input logic             have_base,
    input logic             round_valid,
    input logic [LANES-1:0] lane_bits,
    input logic [LANES-1:0] lane_err
);

    assert_valid_after_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        round_valid |-> $past(recal_done));

    assert_capture_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (recal_done && !have_base) |=> !round_valid);

    assert_rebase_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rebase |=> !round_valid);

    assert_err_excludes_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_bits & lane_err) == '0);

    assert_hold_between_rounds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(recal_done) |-> ($stable(lane_bits) && $stable(lane_err)));

endmodule

bind tap_drift_rx tap_drift_rx_chk #(.LANES(LANES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .recal_done  (recal_done),
    .rebase      (rebase),
    .have_base   (have_base),
    .round_valid (round_valid),
    .lane_bits   (lane_bits),
    .lane_err    (lane_err)
);

// File: tb/tap_drift_rx_tb_top.sv
// Directed bench for the calibration drift receiver.
module tap_drift_rx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LANES = 8;
    localparam int TAP_W = 6;
    localparam int THRESH = 3;
    localparam int MAXS = 12;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   recal_done = 1'b0;
    logic                   rebase = 1'b0;
    logic [LANES*TAP_W-1:0] tap_in = '0;
    logic                   round_valid;
    logic [LANES-1:0]       lane_bits;
    logic [LANES-1:0]       lane_err;

    int checks = 0;
    int errors = 0;
    int base_m [LANES];

    always #(CLK_PERIOD/2) clk = ~clk;

    tap_drift_rx #(.LANES(LANES), .TAP_W(TAP_W), .THRESH(THRESH), .MAX_SHIFT(MAXS)) dut_i (
        .clk(clk), .rst_n(rst_n), .recal_done(recal_done), .rebase(rebase),
        .tap_in(tap_in), .round_valid(round_valid),
        .lane_bits(lane_bits), .lane_err(lane_err)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [LANES*TAP_W-1:0] pack(input int t [LANES]);
        logic [LANES*TAP_W-1:0] v = '0;
        for (int i = 0; i < LANES; i++) v[i*TAP_W +: TAP_W] = TAP_W'(t[i]);
        return v;
    endfunction

    // Drive one round; outputs are sampled at the following falling edge
    task automatic do_round(input int t [LANES], input logic rb);
        @(negedge clk);
        tap_in = pack(t);
        recal_done = 1'b1;
        rebase = rb;
        @(negedge clk);
        recal_done = 1'b0;
        rebase = 1'b0;
    endtask

    // Model expectation for a decode round against the model baselines
    task automatic expect_round(input int t [LANES], input string req);
        logic [LANES-1:0] eb;
        logic [LANES-1:0] ee;
        for (int i = 0; i < LANES; i++) begin
            int d = base_m[i] - t[i];
            ee[i] = (d > MAXS) || (d < -MAXS);
            eb[i] = !ee[i] && (d >= THRESH);
        end
        check({req, " valid"}, int'(round_valid), 1);
        check({req, " bits"}, int'(lane_bits), int'(eb));
        check({req, " err"}, int'(lane_err), int'(ee));
    endtask

    task automatic t_reset();
        check("R1 valid", int'(round_valid), 0);
        check("R1 bits", int'(lane_bits), 0);
        check("R1 err", int'(lane_err), 0);
    endtask

    task automatic t_baseline();
        int t [LANES];
        for (int i = 0; i < LANES; i++) begin t[i] = 30 + i; base_m[i] = t[i]; end
        do_round(t, 1'b0);
        check("R2 no valid on capture", int'(round_valid), 0);
        check("R2 bits stay zero", int'(lane_bits), 0);
    endtask

    // Deltas on the THRESH and MAX_SHIFT edges, a different one per lane (R4-R8)
    task automatic t_edges();
        int t [LANES];
        int dl [LANES] = '{3, 2, 12, 13, -3, -12, -13, 0};
        for (int i = 0; i < LANES; i++) t[i] = base_m[i] - dl[i];
        do_round(t, 1'b0);
        expect_round(t, "R4 R5 R6 R7 R8 edges");
        @(negedge clk);
        check("R3 single-cycle valid", int'(round_valid), 0);
        check("R10 bits hold", int'(lane_bits), 8'b0000_0101);
    endtask

    // Tap changes without a strobe must not reach the outputs (R11)
    task automatic t_ignore();
        int t [LANES];
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            tap_in = {LANES{6'(k * 7)}};
        end
        @(negedge clk);
        check("R11 valid quiet", int'(round_valid), 0);
        check("R11 bits held", int'(lane_bits), 8'b0000_0101);
        check("R11 err held", int'(lane_err), 8'b0100_1000);
        for (int i = 0; i < LANES; i++) t[i] = base_m[i];
        do_round(t, 1'b0);
        expect_round(t, "R10 baseline unchanged");
        check("R10 zero bits", int'(lane_bits), 0);
    endtask

    // A lone rebase, then recapture, then a loaded round on every lane (R9)
    task automatic t_rebase();
        int t [LANES];
        @(negedge clk);
        rebase = 1'b1;
        @(negedge clk);
        rebase = 1'b0;
        for (int i = 0; i < LANES; i++) begin t[i] = 50 - i; base_m[i] = t[i]; end
        do_round(t, 1'b0);
        check("R9 recapture silent", int'(round_valid), 0);
        for (int i = 0; i < LANES; i++) t[i] = base_m[i] - 5;
        do_round(t, 1'b0);
        expect_round(t, "R9 new baseline");
        check("R9 all loaded", int'(lane_bits), 8'hFF);
    endtask

    // Rebase together with the strobe applies to that round (R9)
    task automatic t_rebase_same();
        int t [LANES];
        for (int i = 0; i < LANES; i++) begin t[i] = 20 + 2 * i; base_m[i] = t[i]; end
        do_round(t, 1'b1);
        check("R9 coincident silent", int'(round_valid), 0);
        for (int i = 0; i < LANES; i++) t[i] = base_m[i] - ((i % 2 == 0) ? 4 : 1);
        do_round(t, 1'b0);
        expect_round(t, "R9 coincident baseline");
        check("R9 alternating bits", int'(lane_bits), 8'b0101_0101);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_baseline();
        t_edges();
        t_ignore();
        t_rebase();
        t_rebase_same();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule